// File: doc/BRIEF.md
# Endian-Correcting Pixel Bus Unpacker

This block sits between a 64-bit frame-buffer pixel bus and the pixel pipeline that follows it. It accepts one bus word at a time through a valid/ready handshake and then emits the pixels packed in that word, one per clock. Pixels are taken from the lowest-numbered bus field first. The depth can be 1, 2, 4 or 8 bits for indexed colour, 12, 16 or 24 bits for true colour, or 32 bits.

Boards that store pixels big-endian wire the bus mirrored, so that bus bit 0 carries memory bit 63. This puts the fields in display order, but it also leaves the bits inside each field reversed. When the mode input selects big-endian, the block mirrors the bits inside every field as the field is taken. The field's lowest-numbered bus bit then becomes the pixel's most significant bit. This works the same way at every depth, so one mirrored bus wiring serves every pixel format.

Depth and mode are captured when a word is accepted, and they stay fixed until that word has been fully emitted.

Top module: `pixbus_unpacker`

## Requirements
- R1: While reset is low, and on the first cycle after it, `word_ready_o` is 1, `pix_valid_o` is 0 and `pix_o` is 0. The captured mode after reset is little-endian. A reset in the middle of a word abandons that word.
- R2: A word is accepted on a rising edge where `word_valid_i` and `word_ready_o` are both 1. `word_ready_o` stays 0 while pixels of the word are being emitted, and `word_valid_i` has no effect during that time. `word_ready_o` returns to 1 on the cycle after the last pixel.
- R3: The `depth_i` codes are 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 12 bpp, 5 = 16 bpp, 6 = 24 bpp and 7 = 32 bpp. Each code gives a field slot of S = 1, 2, 4, 8, 16, 16, 32 and 32 bits respectively. A word yields 64/S pixels on consecutive cycles, starting the cycle after it is accepted.
- R4: Pixel k of a word (k = 0 first) comes from bus bits [k*S + S-1 : k*S].
- R5: With `big_endian_i` = 0 at acceptance, pixel bit j equals bus bit k*S + j.
- R6: With `big_endian_i` = 1 at acceptance, pixel bit j equals bus bit k*S + S-1-j. The mirror covers the whole slot at every depth.
- R7: At 12 bpp, the pixel is the low 12 bits of the 16-bit slot after any mirroring, and `pix_o[31:12]` is 0.
- R8: At 24 bpp, the pixel is the low 24 bits of the 32-bit slot after any mirroring, and `pix_o[31:24]` is 0.
- R9: Changes to `depth_i`, `big_endian_i` or `word_i` after a word has been accepted have no effect on that word's pixels.
- R10: `pix_o` is 0 whenever `pix_valid_o` is 0. While `pix_valid_o` is 1, every bit of `pix_o` above the pixel width is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 64 | Bus word, bit n is bus position n |
| word_valid_i | input | 1 | Word present |
| word_ready_o | output | 1 | Block can take a word |
| depth_i | input | 3 | Pixel depth code, captured at acceptance |
| big_endian_i | input | 1 | 1 = mirror bits inside each field, captured at acceptance |
| pix_o | output | 32 | Current pixel, right-aligned |
| pix_valid_o | output | 1 | `pix_o` holds a pixel this cycle |

## Verification
The word, depth and mode are each held in one register, so pixel 0 of a word accepted at rising edge n appears after edge n. Pixel k appears after edge n+k. `word_ready_o` rises after edge n+64/S. The bench drives its inputs and samples the outputs at the falling edge, so each sample falls halfway through the cycle the result is due in. It compares pixel k with a bit-by-bit model of R4 to R8, and it alters the configuration and the word on the bus right after acceptance to exercise R9. After the loop it checks the pixel count and the ready return on the sample following the last pixel.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  localparam int BUS_W = 64;
  localparam int PIX_W = 32;

  typedef enum logic [2:0] {
    DEPTH_1  = 3'd0,
    DEPTH_2  = 3'd1,
    DEPTH_4  = 3'd2,
    DEPTH_8  = 3'd3,
    DEPTH_12 = 3'd4,
    DEPTH_16 = 3'd5,
    DEPTH_24 = 3'd6,
    DEPTH_32 = 3'd7
  } depth_e;

  // log2 of the field slot width
  function automatic logic [2:0] slot_lg(depth_e d);
    case (d)
      DEPTH_1:            return 3'd0;
      DEPTH_2:            return 3'd1;
      DEPTH_4:            return 3'd2;
      DEPTH_8:            return 3'd3;
      DEPTH_12, DEPTH_16: return 3'd4;
      default:            return 3'd5;
    endcase
  endfunction

  function automatic int pix_bits(depth_e d);
    case (d)
      DEPTH_1:  return 1;
      DEPTH_2:  return 2;
      DEPTH_4:  return 4;
      DEPTH_8:  return 8;
      DEPTH_12: return 12;
      DEPTH_16: return 16;
      DEPTH_24: return 24;
      default:  return 32;
    endcase
  endfunction
endpackage

// File: rtl/pbu_bit_mirror.sv
module pbu_bit_mirror #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i] = d_i[W-1-i];
  end
endmodule

// File: rtl/pbu_field_extract.sv
module pbu_field_extract
  import pbu_pkg::*;
#(
  parameter int BUS_W = pbu_pkg::BUS_W,
  parameter int PIX_W = pbu_pkg::PIX_W
) (
  input  logic [BUS_W-1:0]         word_i,
  input  logic [$clog2(BUS_W)-1:0] idx_i,
  input  depth_e                   depth_i,
  input  logic                     be_i,
  output logic [PIX_W-1:0]         pix_o
);
  localparam int IDX_W = $clog2(BUS_W);
  localparam int NUM_W = $clog2(PIX_W) + 1;

  logic [2:0]       lg;
  logic [IDX_W-1:0] shamt;
  logic [BUS_W-1:0] shifted;
  logic [PIX_W-1:0] cand [NUM_W];
  logic [PIX_W-1:0] sel;
  logic [PIX_W-1:0] mask;
  int               pw;

  assign lg      = slot_lg(depth_i);
  assign shamt   = idx_i << lg;
  assign shifted = word_i >> shamt;
  assign pw      = pix_bits(depth_i);

  // one candidate per slot width; the mirror is wired, not muxed per bit
  for (genvar k = 0; k < NUM_W; k++) begin : g_slot
    localparam int SW = 1 << k;
    logic [SW-1:0] raw, mir;
    assign raw = shifted[SW-1:0];
    pbu_bit_mirror #(.W(SW)) u_mir (.d_i(raw), .q_o(mir));
    assign cand[k] = PIX_W'(be_i ? mir : raw);
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_W; k++)
      if (lg == 3'(k)) sel = cand[k];
  end

  always_comb begin
    for (int j = 0; j < PIX_W; j++) mask[j] = (j < pw);
  end

  assign pix_o = sel & mask;
endmodule

// File: rtl/pbu_seq.sv
module pbu_seq #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == last_idx_i) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixbus_unpacker.sv
module pixbus_unpacker
  import pbu_pkg::*;
#(
  parameter int BUS_W = pbu_pkg::BUS_W,
  parameter int PIX_W = pbu_pkg::PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  input  logic [2:0]       depth_i,
  input  logic             big_endian_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o
);
  localparam int IDX_W = $clog2(BUS_W);

  logic [BUS_W-1:0] word_q;
  depth_e           depth_q;
  logic             be_q;
  logic             busy;
  logic             load;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [PIX_W-1:0] pix_raw;

  assign word_ready_o = !busy;
  assign load         = word_valid_i && word_ready_o;
  assign last_idx     = IDX_W'((BUS_W >> slot_lg(depth_q)) - 1);

  // config captured with the word so a word never straddles two settings
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      depth_q <= DEPTH_1;
      be_q    <= 1'b0;
    end else if (load) begin
      word_q  <= word_i;
      depth_q <= depth_e'(depth_i);
      be_q    <= big_endian_i;
    end
  end

  pbu_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .last_idx_i (last_idx),
    .busy_o     (busy),
    .idx_o      (idx)
  );

  pbu_field_extract #(.BUS_W(BUS_W), .PIX_W(PIX_W)) u_ext (
    .word_i  (word_q),
    .idx_i   (idx),
    .depth_i (depth_q),
    .be_i    (be_q),
    .pix_o   (pix_raw)
  );

  assign pix_valid_o = busy;
  assign pix_o       = busy ? pix_raw : '0;
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_valid_i,
  input logic        word_ready_o,
  input logic [2:0]  depth_i,
  input logic [31:0] pix_o,
  input logic        pix_valid_o
);
  logic [7:0]  cnt_q, exp_q;
  logic [31:0] mask_q;

  function automatic logic [7:0] n_pix(logic [2:0] d);
    case (d)
      3'd0: return 8'd64;
      3'd1: return 8'd32;
      3'd2: return 8'd16;
      3'd3: return 8'd8;
      3'd4, 3'd5: return 8'd4;
      default: return 8'd2;
    endcase
  endfunction

  function automatic logic [31:0] wmask(logic [2:0] d);
    case (d)
      3'd0: return 32'h1;
      3'd1: return 32'h3;
      3'd2: return 32'hF;
      3'd3: return 32'hFF;
      3'd4: return 32'hFFF;
      3'd5: return 32'hFFFF;
      3'd6: return 32'hFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      exp_q  <= '0;
      mask_q <= '0;
    end else if (word_valid_i && word_ready_o) begin
      cnt_q  <= '0;
      exp_q  <= n_pix(depth_i);
      mask_q <= wmask(depth_i);
    end else if (pix_valid_o) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  assert_ready_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !word_ready_o);
  assert_accept_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> pix_valid_o);
  assert_ready_return_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_valid_o) |-> word_ready_o);
  assert_pixel_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_valid_o) |-> cnt_q == exp_q);
  assert_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> cnt_q < exp_q);
  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> pix_o == 32'h0);
  // covers R7 and R8 as well: upper bits clear for the captured depth
  assert_width_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_o & ~mask_q) == 32'h0);
endmodule

bind pixbus_unpacker pbu_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .depth_i      (depth_i),
  .pix_o        (pix_o),
  .pix_valid_o  (pix_valid_o)
);

// File: tb/pixbus_unpacker_bench.sv
module pixbus_unpacker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] W1 = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [2:0]  d;
    logic        be;
    logic [63:0] w;
    logic [6:0]  n;
    logic [31:0] first;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 1'b0, W1, 7'd4,  32'h0000_CDEF},
    '{3'd5, 1'b1, W1, 7'd4,  32'h0000_F7B3},
    '{3'd3, 1'b0, W1, 7'd8,  32'h0000_00EF},
    '{3'd3, 1'b1, W1, 7'd8,  32'h0000_00F7},
    '{3'd7, 1'b0, W1, 7'd2,  32'h89AB_CDEF},
    '{3'd7, 1'b1, W1, 7'd2,  32'hF7B3_D591},
    '{3'd6, 1'b0, W1, 7'd2,  32'h00AB_CDEF},
    '{3'd6, 1'b1, W1, 7'd2,  32'h00B3_D591},
    '{3'd4, 1'b0, W1, 7'd4,  32'h0000_0DEF},
    '{3'd4, 1'b1, W1, 7'd4,  32'h0000_07B3},
    '{3'd0, 1'b1, 64'h1, 7'd64, 32'h1},
    '{3'd1, 1'b1, 64'h1, 7'd32, 32'h2},
    '{3'd2, 1'b1, 64'h1, 7'd16, 32'h8},
    '{3'd2, 1'b0, W1, 7'd16, 32'hF},
    '{3'd0, 1'b0, 64'h8000_0000_0000_0000, 7'd64, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [2:0]  depth_i = '0;
  logic        big_endian_i = 1'b0;
  logic [31:0] pix_o;
  logic        pix_valid_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixbus_unpacker u_pixbus_unpacker (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .depth_i      (depth_i),
    .big_endian_i (big_endian_i),
    .pix_o        (pix_o),
    .pix_valid_o  (pix_valid_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bit-level model of R3..R8
  function automatic logic [31:0] model(logic [2:0] d, logic be, logic [63:0] w, int k);
    int s, pw;
    logic [31:0] r = '0;
    case (d)
      3'd0: begin s = 1;  pw = 1;  end
      3'd1: begin s = 2;  pw = 2;  end
      3'd2: begin s = 4;  pw = 4;  end
      3'd3: begin s = 8;  pw = 8;  end
      3'd4: begin s = 16; pw = 12; end
      3'd5: begin s = 16; pw = 16; end
      3'd6: begin s = 32; pw = 24; end
      default: begin s = 32; pw = 32; end
    endcase
    for (int j = 0; j < pw; j++)
      r[j] = be ? w[k*s + s-1-j] : w[k*s + j];
    return r;
  endfunction

  function automatic string req_of(logic [2:0] d, logic be);
    if (d == 3'd4) return "R7";
    if (d == 3'd6) return "R8";
    return be ? "R6" : "R5";
  endfunction

  task automatic run_word(input logic [2:0] d, input logic be, input logic [63:0] w,
                          input int exp_n, input logic [31:0] exp_first);
    int k = 0;
    check(word_ready_o == 1'b1, "R2 ready idle", 64'(word_ready_o), 64'h1);
    word_i = w; depth_i = d; big_endian_i = be; word_valid_i = 1'b1;
    @(negedge clk);
    // R9: scramble config and bus after acceptance; valid held high (R2 ignored while busy)
    word_i = ~w; depth_i = ~d; big_endian_i = ~be;
    while (pix_valid_o && k < 70) begin
      if (k == 0) check(pix_o == exp_first, "R4 first pixel", 64'(pix_o), 64'(exp_first));
      check(pix_o == model(d, be, w, k), {req_of(d, be), " R4 R9 pixel"},
            64'(pix_o), 64'(model(d, be, w, k)));
      check(word_ready_o == 1'b0, "R2 ready low while busy", 64'(word_ready_o), 64'h0);
      k++;
      if (k == exp_n) word_valid_i = 1'b0;
      @(negedge clk);
    end
    word_valid_i = 1'b0;
    check(k == exp_n, "R3 pixel count", 64'(k), 64'(exp_n));
    check(word_ready_o == 1'b1, "R2 ready return", 64'(word_ready_o), 64'h1);
    check(pix_o == 32'h0, "R10 idle pixel zero", 64'(pix_o), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(word_ready_o == 1'b1, "R1 ready in reset", 64'(word_ready_o), 64'h1);
    check(pix_valid_o == 1'b0, "R1 valid in reset", 64'(pix_valid_o), 64'h0);
    check(pix_o == 32'h0, "R1 pixel in reset", 64'(pix_o), 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(word_ready_o == 1'b1 && pix_valid_o == 1'b0, "R1 after reset",
          {62'h0, word_ready_o, pix_valid_o}, 64'h2);

    // R10: valid low while idle keeps pixel zero, even with bus activity
    word_i = W1; depth_i = 3'd7;
    @(negedge clk);
    check(pix_o == 32'h0, "R10 idle zero", 64'(pix_o), 64'h0);

    for (int i = 0; i < NV; i++)
      run_word(VECS[i].d, VECS[i].be, VECS[i].w, int'(VECS[i].n), VECS[i].first);

    // R1: reset mid-word abandons it, mode returns to little-endian capture
    word_i = W1; depth_i = 3'd3; big_endian_i = 1'b1; word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(pix_valid_o == 1'b0 && word_ready_o == 1'b1, "R1 mid-word reset",
          {62'h0, word_ready_o, pix_valid_o}, 64'h2);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pix_valid_o == 1'b0, "R1 no pixels after reset", 64'(pix_valid_o), 64'h0);

    // back-to-back words with changing depth
    run_word(3'd5, 1'b0, 64'hFEDC_BA98_7654_3210, 4, 32'h3210);
    run_word(3'd7, 1'b1, 64'h0000_0001_8000_0000, 2, 32'h0000_0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule